// File: doc/BRIEF.md
# Compare-and-Branch Target Unit

This unit resolves the control-flow outcome of one jump-class instruction per cycle. It receives the current program counter, counted in 64-bit instruction slots, together with a condition code, a compare-width flag and two operands. The first operand is always a register value. The second is either a register value or a 32-bit immediate. The unit decides whether the branch is taken and returns the next program counter. Displacements count slots relative to the slot after the current one.

Eleven conditions are supported: equality, inequality, four unsigned orderings, four signed orderings and a bit test. Two unconditional jumps are also provided, a short one with a 16-bit displacement and a long one with a 32-bit displacement. Call and exit are only reported to the surrounding control logic. In that case the unit returns the sequential address and does not redirect. The register file and instruction fetch belong to the surrounding pipeline.

A request is presented with `in_valid`. All results come from registers and appear on the clock edge after the request.

Top module: `branch_resolve`

## Requirements
- R1: While `rst` is high and after it falls, `out_valid`, `taken`, `next_pc`, `is_call`, `is_exit` and `illegal` are all zero until a request is accepted.
- R2: A request with `in_valid`=1 produces its result with `out_valid`=1 on the next rising edge. A cycle without `in_valid` leaves `out_valid`=0 on the following edge.
- R3: Code 2 (equal) is taken when the operands match, and code 3 (not-equal) is taken when they differ.
- R4: Codes 4, 5, 6 and 7 are the unsigned greater, greater-or-equal, less and less-or-equal conditions, in that order.
- R5: Codes 8, 9, 10 and 11 are the two's-complement signed greater, greater-or-equal, less and less-or-equal conditions, in that order.
- R6: Code 12 (bit test) is taken exactly when the bitwise AND of the two operands is nonzero.
- R7: With `cmp32`=1, only bits 31:0 of both operands take part in the comparison, and bit 31 is the sign bit for the signed codes.
- R8: With `use_imm`=1, the second operand is `imm32` sign-extended to 64 bits, and `op_b` has no effect.
- R9: A taken conditional branch sets `next_pc` = `pc`+1+sign-extended `disp16`. A branch that is not taken sets `next_pc` = `pc`+1. All arithmetic is modulo 2^PC_W.
- R10: Code 0 (short jump) is always taken and uses `disp16`. Code 1 (long jump) is always taken and uses `disp32` sign-extended.
- R11: Code 13 (call) sets `is_call`=1, and code 14 (exit) sets `is_exit`=1. In both cases `taken`=0 and `next_pc`=`pc`+1.
- R12: Code 15 is unused. It sets `illegal`=1, with `taken`=0 and `next_pc`=`pc`+1. At most one of `is_call`, `is_exit` and `illegal` is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| pc | input | PC_W | Current program counter in 64-bit slots |
| cond | input | 4 | Condition code |
| cmp32 | input | 1 | Compare only the low 32 bits |
| op_a | input | DATA_W | First operand (register) |
| op_b | input | DATA_W | Second operand when a register |
| use_imm | input | 1 | Take the second operand from imm32 |
| imm32 | input | 32 | Immediate second operand |
| disp16 | input | 16 | Short signed displacement |
| disp32 | input | 32 | Long signed displacement |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch redirects the program counter |
| next_pc | output | PC_W | Next program counter |
| is_call | output | 1 | Call reported to control |
| is_exit | output | 1 | Exit reported to control |
| illegal | output | 1 | Unused condition code |

## Verification
Sign extension of the immediate and narrowing of the compare to 32 bits can both apply to one instruction. The bench provokes this with an immediate whose bit 31 is set, compared against a register whose upper half holds unrelated bits. It also issues cases where the upper halves differ but the low halves decide, in both widths, so that each combination produces a different taken outcome. A second overlap occurs when the displacement sign and program-counter wrap meet in one target sum. The bench checks this with a long negative jump that lands exactly on slot zero.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;
  typedef enum logic [3:0] {
    C_JMP   = 4'd0,
    C_JMPL  = 4'd1,
    C_EQ    = 4'd2,
    C_NE    = 4'd3,
    C_UGT   = 4'd4,
    C_UGE   = 4'd5,
    C_ULT   = 4'd6,
    C_ULE   = 4'd7,
    C_SGT   = 4'd8,
    C_SGE   = 4'd9,
    C_SLT   = 4'd10,
    C_SLE   = 4'd11,
    C_BTST  = 4'd12,
    C_CALL  = 4'd13,
    C_EXIT  = 4'd14,
    C_BAD   = 4'd15
  } cond_e;
endpackage

// File: rtl/branch_cmp.sv
module branch_cmp
  import branch_resolve_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  cond_e             cond,
  input  logic              cmp32,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              hit
);
  localparam int HALF = DATA_W / 2;

  logic eq_w, ltu_w, lts_w, and_w;
  logic eq_h, ltu_h, lts_h, and_h;
  logic eq, ltu, lts, anz;

  always_comb begin
    eq_w  = (a == b);
    ltu_w = (a < b);
    lts_w = ($signed(a) < $signed(b));
    and_w = |(a & b);
    eq_h  = (a[HALF-1:0] == b[HALF-1:0]);
    ltu_h = (a[HALF-1:0] < b[HALF-1:0]);
    lts_h = ($signed(a[HALF-1:0]) < $signed(b[HALF-1:0]));
    and_h = |(a[HALF-1:0] & b[HALF-1:0]);
    eq    = cmp32 ? eq_h  : eq_w;
    ltu   = cmp32 ? ltu_h : ltu_w;
    lts   = cmp32 ? lts_h : lts_w;
    anz   = cmp32 ? and_h : and_w;
  end

  always_comb begin
    unique case (cond)
      C_JMP, C_JMPL: hit = 1'b1;
      C_EQ:   hit = eq;
      C_NE:   hit = !eq;
      C_UGT:  hit = !ltu && !eq;
      C_UGE:  hit = !ltu;
      C_ULT:  hit = ltu;
      C_ULE:  hit = ltu || eq;
      C_SGT:  hit = !lts && !eq;
      C_SGE:  hit = !lts;
      C_SLT:  hit = lts;
      C_SLE:  hit = lts || eq;
      C_BTST: hit = anz;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/branch_target.sv
module branch_target #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] pc,
  input  logic [15:0]     disp16,
  input  logic [31:0]     disp32,
  input  logic            long_sel,
  output logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] tgt_pc
);
  logic signed [PC_W-1:0] d_ext;

  always_comb begin
    d_ext  = long_sel ? PC_W'($signed(disp32)) : PC_W'($signed(disp16));
    seq_pc = pc + PC_W'(1);
    tgt_pc = seq_pc + d_ext;
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import branch_resolve_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   pc,
  input  logic [3:0]        cond,
  input  logic              cmp32,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              use_imm,
  input  logic [31:0]       imm32,
  input  logic [15:0]       disp16,
  input  logic [31:0]       disp32,
  output logic              out_valid,
  output logic              taken,
  output logic [PC_W-1:0]   next_pc,
  output logic              is_call,
  output logic              is_exit,
  output logic              illegal
);
  cond_e             cc;
  logic [DATA_W-1:0] b_sel;
  logic              hit;
  logic [PC_W-1:0]   seq_pc, tgt_pc;

  assign cc    = cond_e'(cond);
  assign b_sel = use_imm ? DATA_W'($signed(imm32)) : op_b;

  branch_cmp #(.DATA_W(DATA_W)) u_cmp (
    .cond(cc), .cmp32(cmp32), .a(op_a), .b(b_sel), .hit(hit)
  );

  branch_target #(.PC_W(PC_W)) u_tgt (
    .pc(pc), .disp16(disp16), .disp32(disp32), .long_sel(cc == C_JMPL),
    .seq_pc(seq_pc), .tgt_pc(tgt_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      is_call   <= 1'b0;
      is_exit   <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken   <= hit;
        next_pc <= hit ? tgt_pc : seq_pc;
        is_call <= (cc == C_CALL);
        is_exit <= (cc == C_EXIT);
        illegal <= (cc == C_BAD);
      end
    end
  end

  // R2: result follows a request by exactly one edge
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R10: unconditional jumps always redirect
  a_r10_jump_taken: assert property (@(posedge clk) disable iff (rst)
    in_valid && (cond == 4'd0 || cond == 4'd1) |=> taken);
  // R11: call/exit/illegal never redirect and land on the next slot
  a_r11_flag_seq: assert property (@(posedge clk) disable iff (rst)
    in_valid && cond >= 4'd13 |=> !taken && next_pc == $past(pc) + PC_W'(1));
  // R12: side-band flags are mutually exclusive
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_call, is_exit, illegal}));
endmodule

// File: tb/branch_resolve_tb.sv
module branch_resolve_tb;
  localparam int PC_W = 32;
  localparam int DW   = 64;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [PC_W-1:0] pc;
  logic [3:0]      cond;
  logic            cmp32;
  logic [DW-1:0]   op_a, op_b;
  logic            use_imm;
  logic [31:0]     imm32;
  logic [15:0]     disp16;
  logic [31:0]     disp32;
  logic            out_valid, taken, is_call, is_exit, illegal;
  logic [PC_W-1:0] next_pc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  branch_resolve #(.PC_W(PC_W), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pc(pc), .cond(cond),
    .cmp32(cmp32), .op_a(op_a), .op_b(op_b), .use_imm(use_imm),
    .imm32(imm32), .disp16(disp16), .disp32(disp32),
    .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
    .is_call(is_call), .is_exit(is_exit), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register, sample at the next falling edge.
  task automatic issue(input string req, input logic [PC_W-1:0] p, input logic [3:0] c,
                       input logic c32, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic ui, input logic [31:0] im, input logic [15:0] d16,
                       input logic [31:0] d32, input logic exp_t,
                       input logic [PC_W-1:0] exp_pc, input logic [2:0] exp_f);
    pc = p; cond = c; cmp32 = c32; op_a = a; op_b = b; use_imm = ui;
    imm32 = im; disp16 = d16; disp32 = d32; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid"}, 64'(out_valid), 64'd1);
    chk({req, " taken"}, 64'(taken), 64'(exp_t));
    chk({req, " next_pc"}, 64'(next_pc), 64'(exp_pc));
    chk({req, " flags"}, 64'({is_call, is_exit, illegal}), 64'(exp_f));
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; pc = '0; cond = '0; cmp32 = 0; op_a = '0; op_b = '0;
    use_imm = 0; imm32 = '0; disp16 = '0; disp32 = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset", 64'({out_valid, taken, is_call, is_exit, illegal}), 64'd0);
    chk("R1 reset pc", 64'(next_pc), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 64'({out_valid, taken}), 64'd0);
  endtask

  task automatic t_equality;
    issue("R3 eq hit",  100, 4'd2, 0, 64'd5, 64'd5, 0, 0, 16'd10, 0, 1, 111, 3'b000);
    issue("R3 eq miss", 100, 4'd2, 0, 64'd5, 64'd6, 0, 0, 16'd10, 0, 0, 101, 3'b000);
    issue("R3 ne hit",  100, 4'd3, 0, 64'd5, 64'd6, 0, 0, 16'd10, 0, 1, 111, 3'b000);
    // R2: idle cycle gives out_valid low
    @(negedge clk);
    chk("R2 idle", 64'(out_valid), 64'd0);
  endtask

  task automatic t_unsigned;
    issue("R4 ugt",     200, 4'd4, 0, '1, 64'd1, 0, 0, 16'd4, 0, 1, 205, 3'b000);
    issue("R4 uge eq",  200, 4'd5, 0, 64'd9, 64'd9, 0, 0, 16'd4, 0, 1, 205, 3'b000);
    issue("R4 ult",     200, 4'd6, 0, '1, 64'd1, 0, 0, 16'd4, 0, 0, 201, 3'b000);
    issue("R4 ule eq",  200, 4'd7, 0, 64'd9, 64'd9, 0, 0, 16'd4, 0, 1, 205, 3'b000);
  endtask

  task automatic t_signed;
    issue("R5 sgt",     300, 4'd8,  0, '1, 64'd1, 0, 0, 16'd2, 0, 0, 301, 3'b000);
    issue("R5 sge eq",  300, 4'd9,  0, 64'd3, 64'd3, 0, 0, 16'd2, 0, 1, 303, 3'b000);
    issue("R5 slt",     300, 4'd10, 0, '1, 64'd1, 0, 0, 16'd2, 0, 1, 303, 3'b000);
    issue("R5 sle",     300, 4'd11, 0, 64'd4, 64'd3, 0, 0, 16'd2, 0, 0, 301, 3'b000);
  endtask

  task automatic t_bittest;
    issue("R6 btst miss", 50, 4'd12, 0, 64'hF0, 64'h0F, 0, 0, 16'd1, 0, 0, 51, 3'b000);
    issue("R6 btst hit",  50, 4'd12, 0, 64'hF0, 64'h10, 0, 0, 16'd1, 0, 1, 52, 3'b000);
  endtask

  task automatic t_mode32;
    issue("R7 eq32 hit",  60, 4'd2, 1, 64'h1_00000005, 64'h2_00000005, 0, 0, 16'd3, 0, 1, 64, 3'b000);
    issue("R7 eq64 miss", 60, 4'd2, 0, 64'h1_00000005, 64'h2_00000005, 0, 0, 16'd3, 0, 0, 61, 3'b000);
    issue("R7 slt32 hit", 60, 4'd10, 1, 64'h80000000, 64'd0, 0, 0, 16'd3, 0, 1, 64, 3'b000);
    issue("R7 slt64 miss",60, 4'd10, 0, 64'h80000000, 64'd0, 0, 0, 16'd3, 0, 0, 61, 3'b000);
    issue("R7 btst32",    60, 4'd12, 1, 64'hFF_00000000, 64'hFF_00000000, 0, 0, 16'd3, 0, 0, 61, 3'b000);
  endtask

  task automatic t_imm;
    issue("R8 imm sext",  70, 4'd2, 0, '1, 64'd0, 1, 32'hFFFFFFFF, 16'd1, 0, 1, 72, 3'b000);
    issue("R8 imm 32",    70, 4'd10, 1, 64'hAB_00000000, '1, 1, 32'h80000000, 16'd1, 0, 0, 71, 3'b000);
    issue("R8 imm ugt32", 70, 4'd4, 1, 64'h7_FFFFFFFF, 64'd0, 1, 32'h80000000, 16'd1, 0, 1, 72, 3'b000);
  endtask

  task automatic t_jumps;
    issue("R9 neg disp",  100, 4'd2, 0, 64'd1, 64'd1, 0, 0, 16'hFFFB, 0, 1, 96, 3'b000);
    issue("R10 short",    100, 4'd0, 0, 64'd1, 64'd2, 0, 0, 16'd7, 32'h100, 1, 108, 3'b000);
    issue("R10 long",     100, 4'd1, 0, 64'd1, 64'd2, 0, 0, 16'd7, 32'h10000, 1, 65637, 3'b000);
    issue("R10 long wrap",100, 4'd1, 0, 0, 0, 0, 0, 16'd7, 32'hFFFFFF9B, 1, 0, 3'b000);
  endtask

  task automatic t_flags;
    issue("R11 call", 40, 4'd13, 0, 64'd1, 64'd1, 0, 0, 16'd9, 32'd9, 0, 41, 3'b100);
    issue("R11 exit", 40, 4'd14, 0, 64'd1, 64'd1, 0, 0, 16'd9, 32'd9, 0, 41, 3'b010);
    issue("R12 bad",  40, 4'd15, 0, 64'd1, 64'd1, 0, 0, 16'd9, 32'd9, 0, 41, 3'b001);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_equality();
    t_unsigned();
    t_signed();
    t_bittest();
    t_mode32();
    t_imm();
    t_jumps();
    t_flags();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule